// File: doc/BRIEF.md
# Vectored Interrupt Controller with Context Shadow

This block gathers eight interrupt sources: an external pin, four timer channels, an ADC-done event, and the underflow events of a high-time and a low-time down counter. It records every event in a sticky pending flag. It gates the flags with a software mask. While the global enable is set, it picks the highest-priority masked request and hands a 12-bit fetch address to the instruction fetch unit, together with a one-cycle valid strobe.

Software controls the global enable with three command pulses: enable, disable and return-from-interrupt. When an interrupt is taken, the block copies the accumulator and two CPU registers into a single-level shadow. A later interrupt overwrites that shadow. The return command presents the shadow contents back to the core with a one-cycle restore strobe.

Top module: `vic_ctx_top`

## Requirements
- R1: A pulse on `evt_i[k]` sets pending flag k at the next clock edge, whatever the state of the global enable.
- R2: `status_o` equals the bitwise AND of the pending flags and the mask. The bit order is: 0 external, 1 timer A, 2 ADC done, 3 high-time underflow, 4 low-time underflow, 5 timer B, 6 timer C, 7 timer D. `mask_wr_en` loads the mask from `mask_wr_data`.
- R3: `flag_wr_en` loads the flags from `flag_wr_data`. An event that arrives in the same cycle as a write of 0 to that bit still leaves the flag set. A flag changes only through an event or a write.
- R4: After reset the global enable `gie_o` is 0. `cmd_en` sets it at the next edge and `cmd_dis` clears it.
- R5: If `gie_o` is 1 and any bit of `status_o` is 1 at a clock edge, then `vec_valid_o` is 1 for exactly the following cycle and `gie_o` becomes 0 at that same edge. The take also wins over `cmd_en` and `cmd_ret`.
- R6: The vector addresses are 0x003 external, 0x009 timer A, 0x00C ADC, 0x012 high-time, 0x015 low-time, 0x018 timer B, 0x01B timer C and 0x01E timer D.
- R7: When several status bits are set, the lowest vector address (the lowest bit index) wins.
- R8: At a take edge, `acc_i`, `rega_i` and `regb_i` are copied into the shadow. A later take overwrites that copy.
- R9: `cmd_ret` sets `gie_o` at the next edge and raises `restore_valid_o` for one cycle. During that cycle `acc_o`, `rega_o` and `regb_o` carry the shadow copy from the last take.
- R10: A flag that is still set when the return command executes triggers a new interrupt at the edge after the return.
- R11: After reset the flags, the mask, the strobes and the shadow are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 8 | Event pulses, one per source |
| flag_wr_en | input | 1 | Flag register write strobe |
| flag_wr_data | input | 8 | Flag write value |
| mask_wr_en | input | 1 | Mask register write strobe |
| mask_wr_data | input | 8 | Mask write value |
| cmd_en | input | 1 | Global enable command |
| cmd_dis | input | 1 | Global disable command |
| cmd_ret | input | 1 | Return-from-interrupt command |
| acc_i | input | 8 | Live accumulator |
| rega_i | input | 8 | Live CPU register A |
| regb_i | input | 8 | Live CPU register B |
| status_o | output | 8 | Flags AND mask |
| gie_o | output | 1 | Global enable state |
| vec_valid_o | output | 1 | One-cycle interrupt-taken strobe |
| vec_addr_o | output | 12 | Fetch vector address |
| restore_valid_o | output | 1 | One-cycle restore strobe |
| acc_o | output | 8 | Shadow accumulator |
| rega_o | output | 8 | Shadow register A |
| regb_o | output | 8 | Shadow register B |

## Verification
An event reaches `status_o` one edge after it is sampled. The vector strobe follows one edge later, provided the enable is set, so an event arrives as a vector two edges after it is driven. A command changes `gie_o` one edge after it is driven, and the restore strobe appears at that same edge. The bench drives inputs one time unit after a rising edge and samples two units after the edge. A driver pushes each expected vector and restore into queues. A monitor pops an entry on every strobe, and any strobe without a queued entry counts as a failure.

// File: rtl/vic_pkg.sv
// Package: shared widths, source indices and the vector lookup for the
// interrupt controller. Index order equals vector address order, so a
// lower index means a higher priority.
package vic_pkg;
    localparam int NUM_SRC = 8;
    localparam int VEC_W   = 12;
    localparam int DATA_W  = 8;
    localparam int IDX_W   = $clog2(NUM_SRC);

    typedef enum logic [IDX_W-1:0] {
        SRC_EXT   = 3'd0,
        SRC_TMRA  = 3'd1,
        SRC_ADC   = 3'd2,
        SRC_HIGH  = 3'd3,
        SRC_LOW   = 3'd4,
        SRC_TMRB  = 3'd5,
        SRC_TMRC  = 3'd6,
        SRC_TMRD  = 3'd7
    } src_e;

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] rega;
        logic [DATA_W-1:0] regb;
    } ctx_t;

    // Fixed fetch address for each source.
    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        case (src_e'(idx))
            SRC_EXT:  vec_of = 12'h003;
            SRC_TMRA: vec_of = 12'h009;
            SRC_ADC:  vec_of = 12'h00C;
            SRC_HIGH: vec_of = 12'h012;
            SRC_LOW:  vec_of = 12'h015;
            SRC_TMRB: vec_of = 12'h018;
            SRC_TMRC: vec_of = 12'h01B;
            default:  vec_of = 12'h01E;
        endcase
    endfunction
endpackage

// File: rtl/vic_flags.sv
// Module: pending flag and mask registers.
// Each flag is sticky: an event sets it and only a software write clears it.
// An event beats a same-cycle write of 0. The status is flags AND mask.
// Assumes the events are single-cycle pulses that are already synchronous.
module vic_flags #(
    parameter int N = vic_pkg::NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         flag_we,
    input  logic [N-1:0] flag_wd,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wd,
    output logic [N-1:0] status
);
    logic [N-1:0] flags_q;
    logic [N-1:0] mask_q;
    logic [N-1:0] flags_d;

    // Next flag value: a write replaces the flags, then new events are ORed on top.
    always_comb begin
        flags_d = flag_we ? flag_wd : flags_q;
        flags_d = flags_d | evt;
    end

    // Flag storage.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    // Mask storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_wd;
    end

    assign status = flags_q & mask_q;

    // Any event sampled at an edge shows up in the flags after that edge.
    assert_evt_sets_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((flags_q & $past(evt)) == $past(evt)));

    // Without a write, a set flag stays set.
    assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_we) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // Without an event, a write loads exactly the written value.
    assert_flag_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && evt == '0) |=> (flags_q == $past(flag_wd)));
endmodule

// File: rtl/vic_arbiter.sv
// Module: fixed-priority selection among the masked pending requests.
// The lowest index wins, which is also the lowest vector address.
// Purely combinational; assumes status is registered upstream.
module vic_arbiter #(
    parameter int N     = vic_pkg::NUM_SRC,
    parameter int VW    = vic_pkg::VEC_W,
    localparam int IW   = $clog2(N)
) (
    input  logic [N-1:0]  status,
    output logic          pending,
    output logic [VW-1:0] vec_sel
);
    logic [IW-1:0] win_idx;
    logic [N-1:0]  grant;

    // Scan from the highest index down, so the lowest set index is the last one kept.
    always_comb begin
        win_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (status[i]) win_idx = IW'(i);
        end
    end

    // One-hot grant built per bit: a bit is granted only if no lower bit is set.
    for (genvar g = 0; g < N; g++) begin : g_grant
        if (g == 0) begin : g_first
            assign grant[g] = status[g];
        end else begin : g_rest
            assign grant[g] = status[g] & ~(|status[g-1:0]);
        end
    end

    assign pending = |status;
    assign vec_sel = vic_pkg::vec_of(win_idx);

    // The grant is one-hot and agrees with the scanned winner.
    always_comb begin
        if (pending) begin
            assert_grant_onehot_R7: assert ($onehot0(grant) && grant[win_idx]);
        end
    end
endmodule

// File: rtl/vic_gie_ctl.sv
// Module: global enable state and the interrupt-take strobe.
// A take happens when the enable is set and a request is pending. It clears
// the enable and wins over any command in that cycle. After the take, the
// disable command clears the enable, and the enable and return commands set it.
module vic_gie_ctl #(
    parameter int VW = vic_pkg::VEC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pending,
    input  logic [VW-1:0] vec_sel,
    input  logic          cmd_en,
    input  logic          cmd_dis,
    input  logic          cmd_ret,
    output logic          take,
    output logic          gie,
    output logic          vec_valid,
    output logic [VW-1:0] vec_addr
);
    assign take = gie & pending;

    // Global enable update with the take given first priority.
    always_ff @(posedge clk) begin
        if (!rst_n)                gie <= 1'b0;
        else if (take)             gie <= 1'b0;
        else if (cmd_dis)          gie <= 1'b0;
        else if (cmd_en | cmd_ret) gie <= 1'b1;
    end

    // Register the strobe and the address for the fetch unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            vec_addr  <= '0;
        end else begin
            vec_valid <= take;
            if (take) vec_addr <= vec_sel;
        end
    end

    // The strobe comes with the enable already dropped.
    assert_take_clears_gie_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> !gie);
    // The strobe lasts exactly one cycle.
    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);
    // The enable command raises the enable when no take is in progress.
    assert_en_sets_gie_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_en && !cmd_dis && !take) |=> gie);
    // The return command raises the enable when no take is in progress.
    assert_ret_sets_gie_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ret && !cmd_dis && !take) |=> gie);
endmodule

// File: rtl/vic_shadow.sv
// Module: single-level context shadow.
// The shadow captures the live context on every take, so a nested take
// overwrites it. The return command produces a one-cycle restore strobe.
// The shadow outputs always show the stored copy.
module vic_shadow #(
    parameter int DW = vic_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          cmd_ret,
    input  vic_pkg::ctx_t ctx_in,
    output vic_pkg::ctx_t ctx_out,
    output logic          restore_valid
);
    // Capture the context on each take.
    always_ff @(posedge clk) begin
        if (!rst_n)    ctx_out <= '0;
        else if (take) ctx_out <= ctx_in;
    end

    // Pulse the restore strobe one cycle after the return command.
    always_ff @(posedge clk) begin
        if (!rst_n) restore_valid <= 1'b0;
        else        restore_valid <= cmd_ret;
    end

    // A take leaves the live context in the shadow.
    assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (ctx_out == $past(ctx_in)));
    // Without a take the shadow is unchanged.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(ctx_out));
endmodule

// File: rtl/vic_ctx_top.sv
// Module: top of the vectored interrupt controller with context shadow.
// It wires the flags, the arbiter, the enable control and the shadow together.
// Assumes single-cycle command and event pulses from the core and peripherals.
module vic_ctx_top #(
    parameter int N  = vic_pkg::NUM_SRC,
    parameter int VW = vic_pkg::VEC_W,
    parameter int DW = vic_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  evt_i,
    input  logic          flag_wr_en,
    input  logic [N-1:0]  flag_wr_data,
    input  logic          mask_wr_en,
    input  logic [N-1:0]  mask_wr_data,
    input  logic          cmd_en,
    input  logic          cmd_dis,
    input  logic          cmd_ret,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] rega_i,
    input  logic [DW-1:0] regb_i,
    output logic [N-1:0]  status_o,
    output logic          gie_o,
    output logic          vec_valid_o,
    output logic [VW-1:0] vec_addr_o,
    output logic          restore_valid_o,
    output logic [DW-1:0] acc_o,
    output logic [DW-1:0] rega_o,
    output logic [DW-1:0] regb_o
);
    logic          pending;
    logic [VW-1:0] vec_sel;
    logic          take;
    vic_pkg::ctx_t ctx_live;
    vic_pkg::ctx_t ctx_saved;

    assign ctx_live = '{acc: acc_i, rega: rega_i, regb: regb_i};

    vic_flags #(.N(N)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt_i),
        .flag_we (flag_wr_en),
        .flag_wd (flag_wr_data),
        .mask_we (mask_wr_en),
        .mask_wd (mask_wr_data),
        .status  (status_o)
    );

    vic_arbiter #(.N(N), .VW(VW)) u_arb (
        .status  (status_o),
        .pending (pending),
        .vec_sel (vec_sel)
    );

    vic_gie_ctl #(.VW(VW)) u_gie (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending   (pending),
        .vec_sel   (vec_sel),
        .cmd_en    (cmd_en),
        .cmd_dis   (cmd_dis),
        .cmd_ret   (cmd_ret),
        .take      (take),
        .gie       (gie_o),
        .vec_valid (vec_valid_o),
        .vec_addr  (vec_addr_o)
    );

    vic_shadow #(.DW(DW)) u_shadow (
        .clk           (clk),
        .rst_n         (rst_n),
        .take          (take),
        .cmd_ret       (cmd_ret),
        .ctx_in        (ctx_live),
        .ctx_out       (ctx_saved),
        .restore_valid (restore_valid_o)
    );

    assign acc_o  = ctx_saved.acc;
    assign rega_o = ctx_saved.rega;
    assign regb_o = ctx_saved.regb;

    // A pending masked request with the enable set always produces a strobe next cycle.
    assert_pending_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gie_o && status_o != '0) |=> vec_valid_o);
    // No strobe without a masked request and the enable set at the prior edge.
    assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!gie_o || status_o == '0) |=> !vec_valid_o);
endmodule

// File: tb/vic_ctx_top_bench.sv
// Scoreboard bench for vic_ctx_top: the driver queues expected vectors and
// restores, and a monitor pops and compares them on each strobe.
module vic_ctx_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  evt_i = '0;
    logic        flag_wr_en = 1'b0;
    logic [7:0]  flag_wr_data = '0;
    logic        mask_wr_en = 1'b0;
    logic [7:0]  mask_wr_data = '0;
    logic        cmd_en = 1'b0, cmd_dis = 1'b0, cmd_ret = 1'b0;
    logic [7:0]  acc_i = '0, rega_i = '0, regb_i = '0;
    logic [7:0]  status_o;
    logic        gie_o, vec_valid_o, restore_valid_o;
    logic [11:0] vec_addr_o;
    logic [7:0]  acc_o, rega_o, regb_o;

    int total = 0;
    int bad = 0;
    logic [11:0] exp_vec[$];
    logic [23:0] exp_ctx[$];
    logic [11:0] vtab [8] = '{12'h003, 12'h009, 12'h00C, 12'h012,
                              12'h015, 12'h018, 12'h01B, 12'h01E};

    always #2 clk = ~clk;

    vic_ctx_top u_vic_ctx_top (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
        .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
        .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
        .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_ret(cmd_ret),
        .acc_i(acc_i), .rega_i(rega_i), .regb_i(regb_i),
        .status_o(status_o), .gie_o(gie_o), .vec_valid_o(vec_valid_o),
        .vec_addr_o(vec_addr_o), .restore_valid_o(restore_valid_o),
        .acc_o(acc_o), .rega_o(rega_o), .regb_o(regb_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance one edge; the inputs change one unit after it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Drive one-cycle pulses for a single edge, then clear them.
    task automatic pulse_evt(input logic [7:0] e);
        evt_i = e; step(); evt_i = '0;
    endtask
    task automatic write_flags(input logic [7:0] v);
        flag_wr_en = 1'b1; flag_wr_data = v; step(); flag_wr_en = 1'b0;
    endtask
    task automatic write_mask(input logic [7:0] v);
        mask_wr_en = 1'b1; mask_wr_data = v; step(); mask_wr_en = 1'b0;
    endtask
    task automatic do_en();  cmd_en = 1'b1;  step(); cmd_en = 1'b0;  endtask
    task automatic do_dis(); cmd_dis = 1'b1; step(); cmd_dis = 1'b0; endtask
    task automatic do_ret(input logic [23:0] ctx);
        exp_ctx.push_back(ctx);
        cmd_ret = 1'b1; step(); cmd_ret = 1'b0;
    endtask

    // Monitor: sample two units after each edge and compare each strobe with the queues.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && vec_valid_o) begin
                if (exp_vec.size() == 0) check("R5 unexpected vector", {20'h0, vec_addr_o}, 32'hFFFFFFFF);
                else check("R6/R7 vector", {20'h0, vec_addr_o}, {20'h0, exp_vec.pop_front()});
            end
            if (rst_n && restore_valid_o) begin
                if (exp_ctx.size() == 0) check("R9 unexpected restore", 32'h0, 32'hFFFFFFFF);
                else check("R9 restore context", {8'h0, acc_o, rega_o, regb_o}, {8'h0, exp_ctx.pop_front()});
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #400000;
        total++; bad++;
        $display("FAIL watchdog actual=hang expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        // R11: reset state
        check("R11 status", status_o, 0);
        check("R4 gie after reset", gie_o, 0);
        check("R11 strobes", {vec_valid_o, restore_valid_o}, 0);
        check("R11 shadow", {acc_o, rega_o, regb_o}, 0);

        // R1/R2: an event with the enable off still sets the flag
        write_mask(8'hFF);
        pulse_evt(8'h01);
        check("R1 flag set with gie off", status_o, 8'h01);
        step(); step();
        check("R1 no take while disabled", gie_o, 0);

        // R2: a masked-off bit is hidden until the mask opens
        write_mask(8'h0F);
        pulse_evt(8'h20);
        check("R2 masked bit hidden", status_o, 8'h01);
        write_mask(8'hFF);
        check("R2 bit visible after mask", status_o, 8'h21);

        // R3: a write of 0 loses to a same-cycle event
        flag_wr_en = 1'b1; flag_wr_data = 8'h00; evt_i = 8'h04;
        step();
        flag_wr_en = 1'b0; evt_i = '0;
        check("R3 event beats write-0", status_o, 8'h04);
        write_flags(8'h00);
        check("R3 software clear", status_o, 8'h00);

        // R4: enable and disable commands
        do_en();
        check("R4 enable", gie_o, 1);
        do_dis();
        check("R4 disable", gie_o, 0);

        // R5/R7/R8: two events at once; the lower address wins
        acc_i = 8'hA1; rega_i = 8'hB1; regb_i = 8'hC1;
        do_en();
        exp_vec.push_back(12'h012);
        pulse_evt(8'h88);
        step();
        check("R5 gie cleared on take", gie_o, 0);
        check("R8 shadow captured", {acc_o, rega_o, regb_o}, 24'hA1B1C1);

        // R8: a nested take overwrites the shadow
        acc_i = 8'hA2; rega_i = 8'hB2; regb_i = 8'hC2;
        exp_vec.push_back(12'h012);
        do_en();
        step();
        check("R8 nested overwrite", {acc_o, rega_o, regb_o}, 24'hA2B2C2);
        acc_i = 8'h00; rega_i = 8'h00; regb_i = 8'h00;

        // R9/R10: clear the served flag and return; the flag still set retriggers
        write_flags(8'h80);
        exp_vec.push_back(12'h01E);
        do_ret(24'hA2B2C2);
        step();
        check("R10 retrigger clears gie", gie_o, 0);
        write_flags(8'h00);
        step();

        // R6: every source reaches its own address
        for (int i = 0; i < 8; i++) begin
            do_en();
            exp_vec.push_back(vtab[i]);
            pulse_evt(8'h01 << i);
            step();
            check("R6 per-source take", gie_o, 0);
            write_flags(8'h00);
        end

        // R2/R5: a masked-off flag does not trigger even with the enable on
        write_mask(8'h00);
        do_en();
        pulse_evt(8'h40);
        step(); step();
        check("R5 masked no take", gie_o, 1);
        check("R2 status with zero mask", status_o, 8'h00);
        write_flags(8'h00);
        write_mask(8'hFF);
        do_dis();

        step(); step();
        check("queues drained", exp_vec.size() + exp_ctx.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule